// File: doc/BRIEF.md
# Clocked Serial Coprocessor Slave Port

This block sits on the device side of a byte-oriented serial link. The host drives the link clock and one data line. The device answers through an open-drain output that can share that wire with the host. The port oversamples both link inputs with its own system clock and finds the rising and falling edges of the link clock. It shifts each command byte in with the most significant bit first and hands the byte to an internal command engine. Response bytes from the engine are shifted back out on the open-drain line.

The engine may ask for a leading zero ready bit on a response. The line stays released (high) until such a response is loaded, so a host that sees a high line knows it should wait before clocking. Two conditions return the link to a known idle state: a rising edge on data while the link clock is high, and a link clock held high for too long. A small built-in responder answers the link-check command on its own, so the port can be brought up without an engine.

The received-byte stream has no back-pressure, because the host sets the pace. `rx_valid` is a one-cycle pulse, and the engine must take `rx_data` in that cycle. The response path is a valid/ready pair. A byte transfers in a cycle where `tx_load` and `tx_ready` are both high. `tx_load` in any other cycle is dropped.

Top module: `serlink_slave`

## Requirements
- R1: Bits are captured on link clock rising edges, most significant bit first. After every eighth captured bit, `rx_valid` is high for exactly one system cycle with the assembled byte on `rx_data`.
- R2: Changes on `link_din` while the link clock is low have no effect. Only the level present at the rising edge becomes a bit.
- R3: A low-to-high change of `link_din` while the link clock is high discards any partly received byte and any response in progress. The port is then idle and released, ready for a new command.
- R4: A response is accepted only when `tx_load` and `tx_ready` are both high. `tx_load` while `tx_ready` is low is ignored. `tx_ready` stays low until the last bit's clock pulse has ended.
- R5: With `tx_prefix`=1, the port drives a single 0 bit before the data byte, so the response takes 9 clock pulses. With `tx_prefix`=0, the response takes 8 pulses.
- R6: While no response is pending, `link_pull_low` is 0, so the line reads high.
- R7: If the link clock stays high for more than TIMEOUT_CYCLES system cycles, the link state is reset as in R3. This happens while the clock is still high.
- R8: The output is open drain. `link_pull_low`=1 drives the line low and sends a 0. `link_pull_low`=0 releases the line and sends a 1. Each bit is presented before the host's pulse, most significant bit first.
- R9: When the received byte is 8'h08, the port itself loads the response 8'h22 with no ready prefix. This byte is not reported on `rx_valid`.
- R10: The output moves to a new bit only after a link clock falling edge, so the line never goes from driven to released while the clock is high, except during a link reset.
- R11: While a response is pending or being sent, link clock pulses shift the response and are not taken as received bits.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the link clock rate |
| rst_n | input | 1 | Active-low asynchronous reset |
| link_clk | input | 1 | Link clock from the host (asynchronous) |
| link_din | input | 1 | Link data from the host (asynchronous) |
| link_pull_low | output | 1 | Open-drain enable: 1 pulls the line low |
| rx_data | output | 8 | Received command byte |
| rx_valid | output | 1 | One-cycle pulse marking `rx_data` valid |
| tx_data | input | 8 | Response byte from the engine |
| tx_prefix | input | 1 | 1 adds a zero ready bit before the byte |
| tx_load | input | 1 | Valid strobe for the response byte |
| tx_ready | output | 1 | Port can accept a response |

## Verification
The assertions check on every cycle that:
- the line is released while the port is idle;
- `rx_valid` never lasts two cycles;
- an accepted load makes the port busy;
- a prefixed load drives the line low at once;
- the line is released only after a synchronized clock fall or a link reset;
- the clock-high timeout fires exactly at its limit.

Only the bench scenarios can show the byte values: most-significant-bit-first assembly, immunity to glitches while the clock is low, the discarded partial byte after a data-rise reset, the 8'h08 to 8'h22 exchange, and a dropped load while busy.

// File: rtl/serlink_pkg.sv
package serlink_pkg;
  localparam int BYTE_W = 8;
  localparam logic [BYTE_W-1:0] LINKCHK_CMD = 8'h08;
  localparam logic [BYTE_W-1:0] LINKCHK_RSP = 8'h22;

  typedef struct packed {
    logic rise;
    logic fall;
    logic rst;
  } link_evt_t;
endpackage

// File: rtl/serlink_sync.sv
module serlink_sync #(
  parameter int STAGES = 2,
  parameter int WIDTH  = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [WIDTH-1:0] d,
  output logic [WIDTH-1:0] q
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) chain <= '0;
      else        chain <= {chain[STAGES-2:0], d[b]};
    end
    assign q[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/serlink_monitor.sv
module serlink_monitor
  import serlink_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 100_000_000
) (
  input  logic      clk,
  input  logic      rst_n,
  input  logic      clk_s,
  input  logic      din_s,
  output link_evt_t evt
);
  localparam int CW = $clog2(TIMEOUT_CYCLES + 1);

  logic          clk_q, din_q;
  logic [CW-1:0] to_cnt;
  logic          tmo;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      clk_q  <= 1'b0;
      din_q  <= 1'b0;
      to_cnt <= '0;
    end else begin
      clk_q <= clk_s;
      din_q <= din_s;
      if (!clk_s)                           to_cnt <= '0;
      else if (to_cnt != CW'(TIMEOUT_CYCLES)) to_cnt <= to_cnt + 1'b1;
    end
  end

  assign tmo      = clk_s && (to_cnt == CW'(TIMEOUT_CYCLES - 1));
  assign evt.rise = clk_s & ~clk_q;
  assign evt.fall = ~clk_s & clk_q;
  assign evt.rst  = (clk_s & clk_q & din_s & ~din_q) | tmo;
endmodule

// File: rtl/serlink_rx.sv
module serlink_rx
  import serlink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              lrst,
  input  logic              gate,
  input  logic              din_s,
  output logic              done,
  output logic [BYTE_W-1:0] byte_o
);
  localparam int CNT_W = $clog2(BYTE_W);

  logic [CNT_W-1:0]  cnt;
  logic [BYTE_W-2:0] sh;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      sh     <= '0;
      done   <= 1'b0;
      byte_o <= '0;
    end else if (lrst) begin
      cnt  <= '0;
      done <= 1'b0;
    end else begin
      done <= 1'b0;
      if (rise && !gate) begin
        if (cnt == CNT_W'(BYTE_W - 1)) begin
          done   <= 1'b1;
          byte_o <= {sh, din_s};
          cnt    <= '0;
        end else begin
          sh  <= {sh[BYTE_W-3:0], din_s};
          cnt <= cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/serlink_tx.sv
module serlink_tx
  import serlink_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rise,
  input  logic              fall,
  input  logic              lrst,
  input  logic              load,
  input  logic [BYTE_W-1:0] data,
  input  logic              prefix,
  output logic              busy,
  output logic              pull_low
);
  localparam int SW = BYTE_W + 1;
  localparam int LW = $clog2(SW + 1);

  logic [SW-1:0] sh;
  logic [LW-1:0] left;
  logic          armed;

  assign busy     = (left != '0);
  assign pull_low = busy & ~sh[SW-1];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh    <= '1;
      left  <= '0;
      armed <= 1'b0;
    end else if (lrst) begin
      sh    <= '1;
      left  <= '0;
      armed <= 1'b0;
    end else if (load && !busy) begin
      sh    <= prefix ? {1'b0, data} : {data, 1'b1};
      left  <= prefix ? LW'(SW) : LW'(BYTE_W);
      armed <= 1'b0;
    end else if (busy) begin
      if (rise) begin
        armed <= 1'b1;
      end else if (fall && armed) begin
        armed <= 1'b0;
        sh    <= {sh[SW-2:0], 1'b1};
        left  <= left - 1'b1;
      end
    end
  end
endmodule

// File: rtl/serlink_slave.sv
module serlink_slave
  import serlink_pkg::*;
#(
  parameter int TIMEOUT_CYCLES = 100_000_000,
  parameter int SYNC_STAGES    = 2,
  parameter bit LINKCHK_EN     = 1'b1
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              link_clk,
  input  logic              link_din,
  output logic              link_pull_low,
  output logic [BYTE_W-1:0] rx_data,
  output logic              rx_valid,
  input  logic [BYTE_W-1:0] tx_data,
  input  logic              tx_prefix,
  input  logic              tx_load,
  output logic              tx_ready
);
  logic [1:0]        sync_q;
  logic              clk_s, din_s;
  link_evt_t         evt;
  logic              lk_rst;
  logic              rx_done;
  logic [BYTE_W-1:0] rx_byte;
  logic              chk_hit;
  logic              tx_busy;
  logic              ld;
  logic [BYTE_W-1:0] ld_data;
  logic              ld_prefix;

  serlink_sync #(.STAGES(SYNC_STAGES), .WIDTH(2)) u_sync (
    .clk(clk), .rst_n(rst_n), .d({link_clk, link_din}), .q(sync_q)
  );
  assign clk_s = sync_q[1];
  assign din_s = sync_q[0];

  serlink_monitor #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_mon (
    .clk(clk), .rst_n(rst_n), .clk_s(clk_s), .din_s(din_s), .evt(evt)
  );
  assign lk_rst = evt.rst;

  serlink_rx u_rx (
    .clk(clk), .rst_n(rst_n), .rise(evt.rise), .lrst(lk_rst),
    .gate(tx_busy), .din_s(din_s), .done(rx_done), .byte_o(rx_byte)
  );

  if (LINKCHK_EN) begin : g_linkchk
    assign chk_hit = rx_done && (rx_byte == LINKCHK_CMD);
  end else begin : g_nolinkchk
    assign chk_hit = 1'b0;
  end

  assign tx_ready  = ~tx_busy & ~chk_hit;
  assign ld        = chk_hit | (tx_load & tx_ready);
  assign ld_data   = chk_hit ? LINKCHK_RSP : tx_data;
  assign ld_prefix = chk_hit ? 1'b0 : tx_prefix;

  serlink_tx u_tx (
    .clk(clk), .rst_n(rst_n), .rise(evt.rise), .fall(evt.fall),
    .lrst(lk_rst), .load(ld), .data(ld_data), .prefix(ld_prefix),
    .busy(tx_busy), .pull_low(link_pull_low)
  );

  assign rx_valid = rx_done & ~chk_hit;
  assign rx_data  = rx_byte;
endmodule

// File: rtl/serlink_slave_chk.sv
module serlink_slave_chk #(
  parameter int TIMEOUT_CYCLES = 100_000_000
) (
  input logic clk,
  input logic rst_n,
  input logic tx_ready,
  input logic tx_load,
  input logic tx_prefix,
  input logic rx_valid,
  input logic link_pull_low,
  input logic clk_s,
  input logic lk_rst
);
  localparam int HW = $clog2(TIMEOUT_CYCLES + 2);
  logic [HW-1:0] hi_cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                                hi_cnt <= '0;
    else if (!clk_s)                           hi_cnt <= '0;
    else if (hi_cnt != HW'(TIMEOUT_CYCLES + 1)) hi_cnt <= hi_cnt + 1'b1;
  end

  p_idle_released_r6: assert property (@(posedge clk) disable iff (!rst_n)
    tx_ready |-> !link_pull_low);

  p_valid_pulse_r1: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  p_accept_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && tx_ready && !lk_rst) |=> !tx_ready);

  p_prefix_low_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_load && tx_ready && tx_prefix && !lk_rst) |=> link_pull_low);

  p_release_clk_low_r10: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(link_pull_low) |-> (!$past(clk_s) || $past(lk_rst)));

  p_reset_idle_r3: assert property (@(posedge clk) disable iff (!rst_n)
    lk_rst |=> tx_ready);

  p_timeout_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hi_cnt == HW'(TIMEOUT_CYCLES)) |-> $past(lk_rst));
endmodule

bind serlink_slave serlink_slave_chk #(.TIMEOUT_CYCLES(TIMEOUT_CYCLES)) u_chk (
  .clk(clk), .rst_n(rst_n), .tx_ready(tx_ready), .tx_load(tx_load),
  .tx_prefix(tx_prefix), .rx_valid(rx_valid), .link_pull_low(link_pull_low),
  .clk_s(clk_s), .lk_rst(lk_rst)
);

// File: tb/serlink_slave_bench.sv
module serlink_slave_bench;
  localparam int T = 200;
  localparam int H = 16;

  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       link_clk = 1'b0;
  logic       link_din = 1'b1;
  logic       link_pull_low;
  logic [7:0] rx_data;
  logic       rx_valid;
  logic [7:0] tx_data = '0;
  logic       tx_prefix = 1'b0;
  logic       tx_load = 1'b0;
  logic       tx_ready;

  int n_checks = 0;
  int n_fail = 0;
  int rx_cnt = 0;
  logic [7:0] rx_last = '0;
  bit done = 0;

  always #2 clk = ~clk;

  serlink_slave #(.TIMEOUT_CYCLES(T)) u_serlink_slave (
    .clk(clk), .rst_n(rst_n), .link_clk(link_clk), .link_din(link_din),
    .link_pull_low(link_pull_low), .rx_data(rx_data), .rx_valid(rx_valid),
    .tx_data(tx_data), .tx_prefix(tx_prefix), .tx_load(tx_load),
    .tx_ready(tx_ready)
  );

  always @(negedge clk) begin
    if (rx_valid) begin
      rx_cnt++;
      rx_last = rx_data;
    end
  end

  task automatic wt(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic send_bits(input logic [7:0] b, input int n, input bit glitch);
    for (int i = 7; i > 7 - n; i--) begin
      if (glitch) begin
        link_din = ~b[i]; wt(3);
        link_din = b[i];  wt(2);
        link_din = ~b[i]; wt(2);
        link_din = b[i];  wt(H - 7);
      end else begin
        link_din = b[i]; wt(H);
      end
      link_clk = 1'b1; wt(H);
      link_clk = 1'b0; wt(2);
    end
  endtask

  task automatic send_byte(input logic [7:0] b, input bit glitch);
    send_bits(b, 8, glitch);
    link_din = 1'b1;
    wt(H);
  endtask

  task automatic pulse_read(output logic v);
    logic m;
    wt(H);
    v = ~link_pull_low;
    link_clk = 1'b1; wt(2);
    m = ~link_pull_low; wt(H - 2);
    check("R10 line steady while clock high", {31'd0, ~link_pull_low}, {31'd0, m});
    link_clk = 1'b0; wt(2);
  endtask

  task automatic read_byte(output logic [7:0] b);
    logic v;
    for (int i = 7; i >= 0; i--) begin
      pulse_read(v);
      b[i] = v;
    end
    wt(H);
  endtask

  task automatic eng_load(input logic [7:0] d, input bit p);
    tx_data = d; tx_prefix = p; tx_load = 1'b1;
    wt(1);
    tx_load = 1'b0;
    wt(2);
  endtask

  task automatic link_reset_seq();
    link_din = 1'b0; wt(H);
    link_clk = 1'b1; wt(H);
    link_din = 1'b1; wt(H);
    link_clk = 1'b0; wt(H);
  endtask

  task automatic t_reset_state();
    check("R6 reset line released", {31'd0, link_pull_low}, 32'd0);
    check("R4 reset tx_ready", {31'd0, tx_ready}, 32'd1);
    check("R1 reset no rx_valid", rx_cnt, 32'd0);
  endtask

  task automatic t_receive();
    int c0 = rx_cnt;
    send_byte(8'hA5, 0);
    check("R1 one byte pulse", rx_cnt - c0, 32'd1);
    check("R1 byte A5 msb first", {24'd0, rx_last}, 32'hA5);
    send_byte(8'h3C, 0);
    check("R1 byte 3C", {24'd0, rx_last}, 32'h3C);
    send_byte(8'h01, 0);
    check("R1 byte 01", {24'd0, rx_last}, 32'h01);
  endtask

  task automatic t_glitch();
    send_byte(8'h96, 1);
    check("R2 glitches while clock low ignored", {24'd0, rx_last}, 32'h96);
  endtask

  task automatic t_data_rise_reset();
    int c0;
    send_bits(8'hF0, 4, 0);
    c0 = rx_cnt;
    link_reset_seq();
    send_byte(8'h5A, 0);
    check("R3 partial byte discarded count", rx_cnt - c0, 32'd1);
    check("R3 new byte after reset", {24'd0, rx_last}, 32'h5A);
    eng_load(8'h00, 0);
    check("R3 setup line low", {31'd0, link_pull_low}, 32'd1);
    link_reset_seq();
    check("R3 response dropped", {30'd0, tx_ready, link_pull_low}, 32'b10);
  endtask

  task automatic t_send_plain();
    logic [7:0] b;
    int c0 = rx_cnt;
    eng_load(8'hC3, 0);
    check("R4 busy after load", {31'd0, tx_ready}, 32'd0);
    check("R8 first bit 1 released", {31'd0, link_pull_low}, 32'd0);
    read_byte(b);
    check("R8 response C3", {24'd0, b}, 32'hC3);
    check("R4 ready after last pulse", {31'd0, tx_ready}, 32'd1);
    check("R11 no rx during tx", rx_cnt - c0, 32'd0);
    check("R6 released after tx", {31'd0, link_pull_low}, 32'd0);
  endtask

  task automatic t_send_prefix();
    logic [7:0] b;
    logic v;
    check("R6 idle reads high", {31'd0, link_pull_low}, 32'd0);
    eng_load(8'h6E, 1);
    check("R5 ready bit low", {31'd0, link_pull_low}, 32'd1);
    pulse_read(v);
    check("R5 prefix sampled 0", {31'd0, v}, 32'd0);
    read_byte(b);
    check("R5 response 6E", {24'd0, b}, 32'h6E);
    check("R5 done after 9 pulses", {31'd0, tx_ready}, 32'd1);
  endtask

  task automatic t_load_busy();
    logic [7:0] b;
    eng_load(8'h0F, 0);
    eng_load(8'hF0, 1);
    read_byte(b);
    check("R4 load while busy ignored", {24'd0, b}, 32'h0F);
  endtask

  task automatic t_linkchk();
    logic [7:0] b;
    int c0 = rx_cnt;
    send_byte(8'h08, 0);
    check("R9 check byte not forwarded", rx_cnt - c0, 32'd0);
    check("R9 response pending", {31'd0, tx_ready}, 32'd0);
    read_byte(b);
    check("R9 answer 22", {24'd0, b}, 32'h22);
    check("R9 no prefix, idle after 8", {31'd0, tx_ready}, 32'd1);
  endtask

  task automatic t_timeout();
    int c0;
    send_bits(8'hE0, 3, 0);
    link_clk = 1'b1; wt(T + 20);
    link_clk = 1'b0; wt(H);
    c0 = rx_cnt;
    send_byte(8'hE7, 0);
    check("R7 partial cleared by timeout", rx_cnt - c0, 32'd1);
    check("R7 byte after timeout", {24'd0, rx_last}, 32'hE7);
    eng_load(8'h55, 0);
    check("R7 setup line low", {31'd0, link_pull_low}, 32'd1);
    link_clk = 1'b1; wt(T + 20);
    check("R7 tx cleared while clock high", {30'd0, tx_ready, link_pull_low}, 32'b10);
    link_clk = 1'b0; wt(H);
  endtask

  initial begin
    wt(5);
    rst_n = 1'b1;
    wt(5);
    t_reset_state();
    t_receive();
    t_glitch();
    t_data_rise_reset();
    t_send_plain();
    t_send_prefix();
    t_load_busy();
    t_linkchk();
    t_timeout();
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL watchdog all requirements actual=hung expected=finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end
endmodule